// File: doc/BRIEF.md
# Ring Occupancy Near-Full Monitor

This block sits beside a consumer ring and decides how hard the consumer should work on its next pass. A separate interrupt source marks the ring as filling up by pulsing an input. The block holds that mark in a sticky flag. Each time the consumer asks for an evaluation, the block compares the current valid-entry count against two programmable limits: a low limit for "safe" and a high limit for "critical".

While the flag is set and the ring is not yet back below the low limit, the block reports near-full and gives a reap budget that is twice the base budget, saturated to the output width. When an evaluation finds the ring below the low limit, the flag drops. That is the hysteresis: the flag is raised by an external event and released only by occupancy. While the flag is clear, no classification is made and the base budget passes through unchanged.

All outputs are registered and change only on a cycle where the evaluate strobe is high.

Top module: `ring_fill_watch`

## Requirements
- R1: At an evaluation with the flag set, a valid count strictly greater than the critical threshold gives level code 2 (critical).
- R2: At an evaluation with the flag set, a valid count strictly below the safe threshold gives level code 0 (safe). Any other count gives level code 1 (near-full), including a count equal to either threshold.
- R3: An interrupt pulse sets the sticky flag. The flag stays set through evaluations that find code 1 or 2 and through cycles without evaluation. It is cleared only by an evaluation that finds code 0.
- R4: An evaluation made with the flag set and a non-safe level drives near_full_o to 1 and reap_lim_o to twice reap_base_i.
- R5: An evaluation made with the flag clear drives near_full_o to 0 and reap_lim_o to reap_base_i, and leaves level_o unchanged. An evaluation that finds code 0 also gives near_full_o 0 and reap_lim_o equal to reap_base_i.
- R6: level_o, near_full_o and reap_lim_o change only on a clock edge where eval_i is high. The evaluation uses the flag value held before that edge, so an interrupt in the same cycle first takes effect at the next evaluation.
- R7: If an interrupt pulse and a safe-level clear fall on the same edge, the flag ends up set.
- R8: The doubled reap limit saturates at all ones of the reap_lim_o width.
- R9: Reset clears the flag and sets level_o to 0, near_full_o to 0 and reap_lim_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Evaluate strobe |
| irq_i | input | 1 | Near-full interrupt pulse; sets the sticky flag |
| count_i | input | CNT_W (16) | Valid entries in the ring |
| safe_thr_i | input | CNT_W (16) | Safe threshold; counts below it are safe |
| crit_thr_i | input | CNT_W (16) | Critical threshold; counts above it are critical |
| reap_base_i | input | REAP_W (16) | Base per-pass reap budget |
| level_o | output | 2 | Last level code: 0 safe, 1 near-full, 2 critical |
| near_full_o | output | 1 | Near-full result of the last evaluation |
| reap_lim_o | output | REAP_W (16) | Effective reap budget of the last evaluation |

## Verification
The count is swept over every value from 0 to 40 around fixed thresholds of 10 and 30, with the flag re-armed before each evaluation. This separates the three bands and the strict comparisons at both boundaries. A case with both thresholds equal shows that the boundary value itself is near-full. Evaluations with the flag clear show that the level holds while the budget passes straight through. Same-cycle interrupt patterns tell apart "set wins over clear" from "flag sampled before the edge". Base budgets just below, at and above half of full scale show where the doubled budget starts to saturate.

// File: rtl/ring_fill_watch_pkg.sv
package ring_fill_watch_pkg;
   typedef enum logic [1:0] {
      LVL_SAFE = 2'd0,
      LVL_NEAR = 2'd1,
      LVL_CRIT = 2'd2
   } fill_level_e;
endpackage

// File: rtl/fill_level_classify.sv
module fill_level_classify
   import ring_fill_watch_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] safe_thr_i,
   input  logic [CNT_W-1:0] crit_thr_i,
   output fill_level_e      level_o
);
   // critical is tested first, so it takes precedence when thresholds overlap
   always_comb begin
      if (count_i > crit_thr_i)
         level_o = LVL_CRIT;
      else if (count_i < safe_thr_i)
         level_o = LVL_SAFE;
      else
         level_o = LVL_NEAR;
   end
endmodule

// File: rtl/sticky_fill_flag.sv
module sticky_fill_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   // the set is tested first, so it wins over a clear on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end
endmodule

// File: rtl/reap_budget_scale.sv
module reap_budget_scale #(
   parameter int REAP_W     = 16,
   parameter int SCALE_LOG2 = 1
) (
   input  logic [REAP_W-1:0] base_i,
   output logic [REAP_W-1:0] scaled_o
);
   localparam int WIDE_W = REAP_W + SCALE_LOG2;

   generate
      if (SCALE_LOG2 == 0) begin : g_pass
         assign scaled_o = base_i;
      end else begin : g_shift
         logic [WIDE_W-1:0] wide;
         assign wide = {{SCALE_LOG2{1'b0}}, base_i} << SCALE_LOG2;
         // any bit shifted past the output width means overflow: clamp to all ones
         assign scaled_o = (|wide[WIDE_W-1:REAP_W]) ? {REAP_W{1'b1}}
                                                    : wide[REAP_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/ring_fill_watch.sv
module ring_fill_watch
   import ring_fill_watch_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int REAP_W     = 16,
   parameter int SCALE_LOG2 = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval_i,
   input  logic              irq_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [CNT_W-1:0]  safe_thr_i,
   input  logic [CNT_W-1:0]  crit_thr_i,
   input  logic [REAP_W-1:0] reap_base_i,
   output logic [1:0]        level_o,
   output logic              near_full_o,
   output logic [REAP_W-1:0] reap_lim_o
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("ring_fill_watch: CNT_W must be at least 2");
      end
      if (REAP_W < 2) begin : g_bad_reap
         $error("ring_fill_watch: REAP_W must be at least 2");
      end
      if (SCALE_LOG2 < 0 || SCALE_LOG2 > 8) begin : g_bad_scale
         $error("ring_fill_watch: SCALE_LOG2 must be within 0..8");
      end
   endgenerate

   fill_level_e       cls;
   logic              flag_q;
   logic              clr_flag;
   logic [REAP_W-1:0] scaled;
   fill_level_e       level_q;
   logic              nf_q;
   logic [REAP_W-1:0] reap_q;

   fill_level_classify #(.CNT_W(CNT_W)) u_cls (
      .count_i    (count_i),
      .safe_thr_i (safe_thr_i),
      .crit_thr_i (crit_thr_i),
      .level_o    (cls)
   );

   // only an evaluation that runs with the flag set and finds the safe band clears it
   assign clr_flag = eval_i && flag_q && (cls == LVL_SAFE);

   sticky_fill_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (irq_i),
      .clr_i  (clr_flag),
      .flag_o (flag_q)
   );

   reap_budget_scale #(.REAP_W(REAP_W), .SCALE_LOG2(SCALE_LOG2)) u_scale (
      .base_i   (reap_base_i),
      .scaled_o (scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= LVL_SAFE;
         nf_q    <= 1'b0;
         reap_q  <= '0;
      end else if (eval_i) begin
         if (flag_q) begin
            level_q <= cls;
            nf_q    <= (cls != LVL_SAFE);
            reap_q  <= (cls != LVL_SAFE) ? scaled : reap_base_i;
         end else begin
            nf_q   <= 1'b0;
            reap_q <= reap_base_i;
         end
      end
   end

   assign level_o     = level_q;
   assign near_full_o = nf_q;
   assign reap_lim_o  = reap_q;
endmodule

// File: rtl/ring_fill_watch_chk.sv
module ring_fill_watch_chk #(
   parameter int CNT_W  = 16,
   parameter int REAP_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eval_i,
   input logic              irq_i,
   input logic [CNT_W-1:0]  count_i,
   input logic [CNT_W-1:0]  crit_thr_i,
   input logic [REAP_W-1:0] reap_base_i,
   input logic              flag_q,
   input logic [1:0]        level_o,
   input logic              near_full_o,
   input logic [REAP_W-1:0] reap_lim_o
);
   // R6
   outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_i |=> ($stable(level_o) && $stable(near_full_o) && $stable(reap_lim_o)));

   // R3
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i |=> flag_q);

   // R3
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !eval_i) |=> flag_q);

   // R5
   no_flag_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_i && !flag_q) |=> (!near_full_o && reap_lim_o == $past(reap_base_i)));

   // R1
   crit_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_i && flag_q && count_i > crit_thr_i) |=> (level_o == 2'd2 && near_full_o));

   // R4
   nf_not_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      near_full_o |-> (level_o != 2'd0));
endmodule

bind ring_fill_watch ring_fill_watch_chk #(.CNT_W(CNT_W), .REAP_W(REAP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .eval_i      (eval_i),
   .irq_i       (irq_i),
   .count_i     (count_i),
   .crit_thr_i  (crit_thr_i),
   .reap_base_i (reap_base_i),
   .flag_q      (flag_q),
   .level_o     (level_o),
   .near_full_o (near_full_o),
   .reap_lim_o  (reap_lim_o)
);

// File: tb/ring_fill_watch_bench.sv
`timescale 1ns/1ps
module ring_fill_watch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eval_i = 1'b0;
   logic        irq_i = 1'b0;
   logic [15:0] count_i = '0;
   logic [15:0] safe_thr_i = '0;
   logic [15:0] crit_thr_i = '0;
   logic [15:0] reap_base_i = '0;
   logic [1:0]  level_o;
   logic        near_full_o;
   logic [15:0] reap_lim_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // bench-side reference state
   bit          m_flag = 0;
   logic [1:0]  m_lvl = 2'd0;
   bit          m_nf = 0;
   logic [15:0] m_reap = '0;

   always #10 clk = ~clk;

   ring_fill_watch u_ring_fill_watch (
      .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .irq_i(irq_i),
      .count_i(count_i), .safe_thr_i(safe_thr_i), .crit_thr_i(crit_thr_i),
      .reap_base_i(reap_base_i), .level_o(level_o),
      .near_full_o(near_full_o), .reap_lim_o(reap_lim_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] dbl(input logic [15:0] b);
      int v;
      v = 2 * int'(b);
      return (v > 65535) ? 16'hFFFF : 16'(v);
   endfunction

   // Drive at a falling edge, let one rising edge pass, update the reference, and
   // return at the next falling edge.
   task automatic cyc(input logic [15:0] c, input logic [15:0] s, input logic [15:0] k,
                      input logic [15:0] b, input bit irq, input bit ev);
      bit fb;
      logic [1:0] cl;
      count_i = c; safe_thr_i = s; crit_thr_i = k; reap_base_i = b;
      irq_i = irq; eval_i = ev;
      @(posedge clk);
      fb = m_flag;
      if (ev) begin
         if (fb) begin
            cl = (c > k) ? 2'd2 : ((c < s) ? 2'd0 : 2'd1);
            m_lvl = cl;
            m_nf = (cl != 2'd0);
            m_reap = (cl != 2'd0) ? dbl(b) : b;
            if (cl == 2'd0) m_flag = 0;
         end else begin
            m_nf = 0;
            m_reap = b;
         end
      end
      if (irq) m_flag = 1;
      @(negedge clk);
      irq_i = 1'b0; eval_i = 1'b0;
   endtask

   task automatic check_all(input string tag);
      chk(level_o == m_lvl, {tag, " level"}, level_o, m_lvl);
      chk(near_full_o == m_nf, {tag, " near_full"}, near_full_o, m_nf);
      chk(reap_lim_o == m_reap, {tag, " reap"}, reap_lim_o, m_reap);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset values
      check_all("R9 reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R9: flag starts clear, so an evaluation passes the budget through
      cyc(16'd35, 16'd10, 16'd30, 16'd100, 0, 1);
      check_all("R9 R5 flag clear after reset");

      // R1 R2 R4: full band sweep with the flag re-armed before each evaluation
      for (int c = 0; c <= 40; c++) begin
         cyc(16'd0, 16'd10, 16'd30, 16'd100, 1, 0);
         cyc(16'(c), 16'd10, 16'd30, 16'd100, 0, 1);
         check_all($sformatf("R1 R2 R4 sweep count=%0d", c));
      end

      // R5: the last sweep value (40) was critical, so the flag is still set; clear it
      cyc(16'd3, 16'd10, 16'd30, 16'd100, 0, 1);
      check_all("R3 R5 safe clear");
      cyc(16'd35, 16'd10, 16'd30, 16'd77, 0, 1);
      check_all("R5 no flag, level held");

      // R3: flag holds across non-safe evaluations and idle cycles
      cyc(16'd0, 16'd10, 16'd30, 16'd50, 1, 0);
      cyc(16'd20, 16'd10, 16'd30, 16'd50, 0, 1);
      check_all("R3 first near");
      repeat (4) cyc(16'd2, 16'd10, 16'd30, 16'd50, 0, 0);
      cyc(16'd31, 16'd10, 16'd30, 16'd50, 0, 1);
      check_all("R3 still set, critical");

      // R6: no evaluation -> outputs hold despite input changes
      cyc(16'd0, 16'd10, 16'd30, 16'd9, 0, 0);
      check_all("R6 hold without eval");

      // R7: interrupt together with a safe clear keeps the flag
      cyc(16'd1, 16'd10, 16'd30, 16'd50, 1, 1);
      check_all("R7 safe eval with irq");
      cyc(16'd25, 16'd10, 16'd30, 16'd50, 0, 1);
      check_all("R7 flag survived");

      // R6: irq on the same edge as an evaluation with the flag clear
      cyc(16'd1, 16'd10, 16'd30, 16'd50, 0, 1);
      cyc(16'd25, 16'd10, 16'd30, 16'd60, 1, 1);
      check_all("R6 irq same edge not seen");
      cyc(16'd25, 16'd10, 16'd30, 16'd60, 0, 1);
      check_all("R6 irq seen next eval");

      // R2: equal thresholds, boundary value is near-full
      cyc(16'd20, 16'd20, 16'd20, 16'd5, 0, 1);
      check_all("R2 equal thresholds at boundary");
      cyc(16'd21, 16'd20, 16'd20, 16'd5, 0, 1);
      check_all("R1 equal thresholds above");

      // R8: saturation of the doubled budget
      cyc(16'd25, 16'd10, 16'd30, 16'h7FFF, 0, 1);
      check_all("R8 just below half scale");
      cyc(16'd25, 16'd10, 16'd30, 16'h8000, 0, 1);
      check_all("R8 half scale");
      cyc(16'd25, 16'd10, 16'd30, 16'hFFFF, 0, 1);
      check_all("R8 full scale");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule